// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block translates a 64-bit virtual address into a 52-bit physical address by reading up to four levels of 64-bit translation entries from memory. A walk starts from a root table base. At each level nine virtual-address bits pick an entry. The entry supplies the base of the next table, or ends the walk as a leaf. A leaf is an entry at the lowest level, or a large-page entry at one of the two middle levels.

The walker accepts one request at a time. It rejects addresses whose upper bits are not a sign extension of bit 47. It checks the present bit and the reserved bits of every entry, and it checks that large-page frames are aligned. Permission bits from all levels are merged into one result. Any entry that lacks its accessed flag is written back with the flag set, and a write access also sets the dirty flag on the leaf. Final permission decisions and caching of results are left to the logic that consumes the outputs.

Top module: `pt_walker`

## Requirements
- R1: The entry for level L (3 = top, 0 = lowest) is read at the current table base plus 8 times the 9-bit index taken from virtual-address bits [12+9L+8 : 12+9L]. The root base and each later base come from bits 51:12 of the previous entry, with bits 11:0 taken as zero.
- R2: When bits 63:47 of the virtual address are not all equal, the walker reads no memory. It signals done one cycle after the strobe with fault_code 1.
- R3: An entry whose bit 0 (present) is clear ends the walk with fault_code 2. No later level is read.
- R4: An entry ends the walk with fault_code 3 in any of these cases: bit 7 is set at level 3; any bit from PHYS_BITS up to 51 is set; or bit 63 is set while nx_enable is low.
- R5: perm is {exec_ok, user, writable}. The walk starts with all three set. At every level, exec_ok is ANDed with the inverse of entry bit 63, user with bit 2 and writable with bit 1.
- R6: Bit 7 set at level 2 ends the walk with a 1 GiB page (page_size 2), and at level 1 with a 2 MiB page (page_size 1). A leaf at level 0 gives page_size 0. In a large-page leaf, any set bit from 13 up to the page-size bit minus one gives fault_code 3. Bit 12 is exempt from this check.
- R7: An entry whose bit 5 (accessed) is clear is written back to its own address with bit 5 set, before the walk goes on. An entry with bit 5 already set on a read or fetch is not written.
- R8: On a write access (req_access 1), a leaf whose bit 6 (dirty) is clear is written back with bits 5 and 6 set. Read (0) and fetch (2) accesses never set bit 6.
- R9: On success, pa is the leaf frame (bits 51:12) with the bits below the page size cleared, plus the virtual address bits below the page size. fault_code is 0.
- R10: A memory request holds its address, write flag and data until mem_req_ready is seen. done is a one-cycle pulse. A req_valid that arrives while busy is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start strobe, taken while idle |
| req_vaddr | input | 64 | Virtual address to translate |
| req_access | input | 2 | 0 read, 1 write, 2 fetch |
| root_base | input | 52 | Top-level table base |
| nx_enable | input | 1 | Bit 63 of entries is a no-execute flag when high, reserved when low |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle completion pulse |
| fault_code | output | 2 | 0 none, 1 non-canonical, 2 not present, 3 reserved bit |
| page_size | output | 2 | 0 4 KiB, 1 2 MiB, 2 1 GiB |
| pa | output | 52 | Translated physical address |
| perm | output | 3 | {exec_ok, user, writable} |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | Request is an entry write-back |
| mem_req_addr | output | 52 | Entry address |
| mem_req_wdata | output | 64 | Write-back data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data |

## Verification
A non-canonical address is rejected one cycle after the strobe edge, with no memory request. Every other walk costs, per level, one request cycle plus any stall, the response latency, one evaluation cycle, and a write-back handshake where needed. The bench therefore takes results when done rises at a falling edge, and it counts reads and writes in its memory model. A second strobe is injected during a walk that runs with stalls and slow responses; five idle cycles afterwards confirm that no extra done pulse and no extra read appear.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;
  localparam int PA_W     = 52;
  localparam int VA_W     = 64;
  localparam int ENT_W    = 64;
  localparam int IDX_W    = 9;
  localparam int PG_SHIFT = 12;
  localparam int LVL_W    = 2;

  localparam int B_P  = 0;
  localparam int B_RW = 1;
  localparam int B_US = 2;
  localparam int B_A  = 5;
  localparam int B_D  = 6;
  localparam int B_PS = 7;
  localparam int B_NX = 63;

  typedef enum logic [1:0] {FLT_NONE = 2'd0, FLT_GP = 2'd1, FLT_NP = 2'd2, FLT_RSV = 2'd3} fault_e;
  typedef enum logic [1:0] {PG_4K = 2'd0, PG_2M = 2'd1, PG_1G = 2'd2} pgsz_e;

  function automatic logic [IDX_W-1:0] f_index(input logic [VA_W-1:0] va, input logic [LVL_W-1:0] lvl);
    return va[PG_SHIFT + IDX_W*int'(lvl) +: IDX_W];
  endfunction

  function automatic logic f_canonical(input logic [VA_W-1:0] va);
    return (&va[63:47]) | ~(|va[63:47]);
  endfunction

  function automatic logic [ENT_W-1:0] f_page_mask(input logic [LVL_W-1:0] lvl);
    case (lvl)
      2'd2:    return (64'd1 << 30) - 64'd1;
      2'd1:    return (64'd1 << 21) - 64'd1;
      default: return (64'd1 << PG_SHIFT) - 64'd1;
    endcase
  endfunction

  function automatic logic [ENT_W-1:0] f_rsvd_mask(input int phys_bits, input logic nx_en);
    logic [ENT_W-1:0] m;
    for (int i = 0; i < ENT_W; i++) m[i] = (i >= phys_bits) && (i < PA_W);
    m[B_NX] = ~nx_en;
    return m;
  endfunction

  function automatic logic [PA_W-1:0] f_leaf_pa(input logic [ENT_W-1:0] ent, input logic [VA_W-1:0] va,
                                                input logic [LVL_W-1:0] lvl);
    logic [PA_W-1:0] pm;
    pm = f_page_mask(lvl)[PA_W-1:0];
    return ({ent[PA_W-1:PG_SHIFT], {PG_SHIFT{1'b0}}} & ~pm) | (va[PA_W-1:0] & pm);
  endfunction
endpackage

// File: rtl/pt_addr_gen.sv
module pt_addr_gen
  import pt_walk_pkg::*;
(
  input  logic [VA_W-1:0]  new_vaddr,
  input  logic [VA_W-1:0]  walk_vaddr,
  input  logic [PA_W-1:0]  table_base,
  input  logic [LVL_W-1:0] level,
  output logic [PA_W-1:0]  entry_addr,
  output logic             canonical
);
  logic [IDX_W-1:0] idx;

  always_comb begin
    idx        = f_index(walk_vaddr, level);
    entry_addr = table_base + {{(PA_W-IDX_W-3){1'b0}}, idx, 3'b000};
    canonical  = f_canonical(new_vaddr);
  end
endmodule

// File: rtl/pt_entry_eval.sv
module pt_entry_eval
  import pt_walk_pkg::*;
#(
  parameter int PHYS_BITS = 40
) (
  input  logic [ENT_W-1:0] entry,
  input  logic [LVL_W-1:0] level,
  input  logic [VA_W-1:0]  vaddr,
  input  logic             is_write,
  input  logic             nx_en,
  input  logic [2:0]       prot_in,
  output fault_e           fault,
  output logic             is_leaf,
  output logic             wb_need,
  output logic [ENT_W-1:0] wb_data,
  output logic [2:0]       prot_out,
  output logic [PA_W-1:0]  next_base,
  output logic [PA_W-1:0]  leaf_pa,
  output pgsz_e            leaf_size
);
  localparam logic [ENT_W-1:0] LOW_FLAGS = 64'h1FFF;

  logic ps_leaf, rsv, misalign;
  logic [ENT_W-1:0] pmask;

  always_comb begin
    pmask    = f_page_mask(level);
    ps_leaf  = entry[B_PS] && (level == 2'd2 || level == 2'd1);
    is_leaf  = (level == 2'd0) || ps_leaf;
    rsv      = (|(entry & f_rsvd_mask(PHYS_BITS, nx_en))) || (level == 2'd3 && entry[B_PS]);
    misalign = ps_leaf && (|(entry & pmask & ~LOW_FLAGS));
    if (!entry[B_P])          fault = FLT_NP;
    else if (rsv || misalign) fault = FLT_RSV;
    else                      fault = FLT_NONE;
    wb_data        = entry;
    wb_data[B_A]   = 1'b1;
    if (is_leaf && is_write) wb_data[B_D] = 1'b1;
    wb_need   = (wb_data != entry);
    prot_out  = prot_in & {~entry[B_NX], entry[B_US], entry[B_RW]};
    next_base = {entry[PA_W-1:PG_SHIFT], {PG_SHIFT{1'b0}}};
    leaf_pa   = f_leaf_pa(entry, vaddr, level);
    case (level)
      2'd2:    leaf_size = PG_1G;
      2'd1:    leaf_size = PG_2M;
      default: leaf_size = PG_4K;
    endcase
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walk_pkg::*;
#(
  parameter int PHYS_BITS = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [63:0]      req_vaddr,
  input  logic [1:0]       req_access,
  input  logic [51:0]      root_base,
  input  logic             nx_enable,
  output logic             busy,
  output logic             done,
  output logic [1:0]       fault_code,
  output logic [1:0]       page_size,
  output logic [51:0]      pa,
  output logic [2:0]       perm,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic             mem_req_write,
  output logic [51:0]      mem_req_addr,
  output logic [63:0]      mem_req_wdata,
  input  logic             mem_rsp_valid,
  input  logic [63:0]      mem_rsp_data
);
  typedef enum logic [2:0] {S_IDLE, S_RD, S_WAIT, S_EVAL, S_WB, S_FIN} state_e;

  state_e           state;
  logic [VA_W-1:0]  va_q;
  logic             wr_q, nx_q;
  logic [LVL_W-1:0] lvl_q;
  logic [PA_W-1:0]  base_q, pa_q;
  logic [ENT_W-1:0] ent_q;
  logic [2:0]       prot_q;
  fault_e           fault_q;
  pgsz_e            size_q;

  logic [PA_W-1:0]  ent_addr;
  logic             canon;
  fault_e           ev_fault;
  logic             ev_leaf, ev_wb;
  logic [ENT_W-1:0] ev_wb_data;
  logic [2:0]       ev_prot;
  logic [PA_W-1:0]  ev_next, ev_pa;
  pgsz_e            ev_size;

  // named events for the checker
  logic accept, gp_hit, np_hit, rsv_hit, walk_advance;

  pt_addr_gen u_addr (
    .new_vaddr(req_vaddr), .walk_vaddr(va_q), .table_base(base_q), .level(lvl_q),
    .entry_addr(ent_addr), .canonical(canon)
  );

  pt_entry_eval #(.PHYS_BITS(PHYS_BITS)) u_eval (
    .entry(ent_q), .level(lvl_q), .vaddr(va_q), .is_write(wr_q), .nx_en(nx_q),
    .prot_in(prot_q), .fault(ev_fault), .is_leaf(ev_leaf), .wb_need(ev_wb),
    .wb_data(ev_wb_data), .prot_out(ev_prot), .next_base(ev_next), .leaf_pa(ev_pa),
    .leaf_size(ev_size)
  );

  assign accept       = (state == S_IDLE) && req_valid;
  assign gp_hit       = accept && !canon;
  assign np_hit       = (state == S_EVAL) && (ev_fault == FLT_NP);
  assign rsv_hit      = (state == S_EVAL) && (ev_fault == FLT_RSV);
  assign walk_advance = ((state == S_EVAL) && (ev_fault == FLT_NONE) && !ev_wb) ||
                        ((state == S_WB) && mem_req_ready);

  assign busy          = (state != S_IDLE);
  assign done          = (state == S_FIN);
  assign fault_code    = fault_q;
  assign page_size     = size_q;
  assign pa            = pa_q;
  assign perm          = prot_q;
  assign mem_req_valid = (state == S_RD) || (state == S_WB);
  assign mem_req_write = (state == S_WB);
  assign mem_req_addr  = ent_addr;
  assign mem_req_wdata = ev_wb_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      va_q    <= '0;
      wr_q    <= 1'b0;
      nx_q    <= 1'b0;
      lvl_q   <= '0;
      base_q  <= '0;
      pa_q    <= '0;
      ent_q   <= '0;
      prot_q  <= '0;
      fault_q <= FLT_NONE;
      size_q  <= PG_4K;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          va_q   <= req_vaddr;
          wr_q   <= (req_access == 2'd1);
          nx_q   <= nx_enable;
          lvl_q  <= 2'd3;
          base_q <= {root_base[PA_W-1:PG_SHIFT], {PG_SHIFT{1'b0}}};
          prot_q <= 3'b111;
          if (!canon) begin
            fault_q <= FLT_GP;
            state   <= S_FIN;
          end else begin
            state <= S_RD;
          end
        end
        S_RD:   if (mem_req_ready) state <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          ent_q <= mem_rsp_data;
          state <= S_EVAL;
        end
        S_EVAL: if (ev_fault != FLT_NONE) begin
          fault_q <= ev_fault;
          state   <= S_FIN;
        end else if (ev_wb) begin
          state <= S_WB;
        end
        S_FIN:  state <= S_IDLE;
        default: ;
      endcase
      if (walk_advance) begin
        prot_q <= ev_prot;
        if (ev_leaf) begin
          pa_q    <= ev_pa;
          size_q  <= ev_size;
          fault_q <= FLT_NONE;
          state   <= S_FIN;
        end else begin
          lvl_q  <= lvl_q - 2'd1;
          base_q <= ev_next;
          state  <= S_RD;
        end
      end
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        gp_hit,
  input logic        np_hit,
  input logic        rsv_hit,
  input logic        done,
  input logic [1:0]  fault_code,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic        mem_req_write,
  input logic [51:0] mem_req_addr,
  input logic [63:0] mem_req_wdata
);
  AST_ENTRY_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[2:0] == 3'd0); // R1
  AST_GP_NO_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    gp_hit |=> done && fault_code == 2'd1 && !mem_req_valid); // R2
  AST_NP_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    np_hit |=> done && fault_code == 2'd2 && !mem_req_valid); // R3
  AST_RSV_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    rsv_hit |=> done && fault_code == 2'd3 && !mem_req_valid); // R4
  AST_WB_ACCESSED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_write |-> mem_req_wdata[5] && mem_req_wdata[0]); // R7
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) &&
    $stable(mem_req_write) && $stable(mem_req_wdata)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
endmodule

bind pt_walker pt_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .gp_hit(gp_hit), .np_hit(np_hit), .rsv_hit(rsv_hit),
  .done(done), .fault_code(fault_code), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
  .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata)
);

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [63:0] req_vaddr = '0;
  logic [1:0]  req_access = '0;
  logic [51:0] root_base = 52'h1000;
  logic        nx_enable = 1'b1;
  logic        busy, done, mem_req_valid, mem_req_write;
  logic [1:0]  fault_code, page_size;
  logic [51:0] pa, mem_req_addr;
  logic [2:0]  perm;
  logic [63:0] mem_req_wdata;
  logic        mem_req_ready = 1'b1;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;

  logic [63:0] mem [logic [51:0]];
  int n_chk = 0, n_bad = 0;
  int rd_cnt = 0, wr_cnt = 0;
  logic [51:0] last_waddr;
  logic [63:0] last_wdata;
  logic        stall = 1'b0;
  int          rsp_lat = 1;
  logic        pend = 1'b0;
  int          pend_cnt = 0;
  logic [51:0] pend_addr = '0;
  int          rd0, wr0;
  logic [1:0]  r_fault, r_size;
  logic [51:0] r_pa;
  logic [2:0]  r_perm;

  always #10 clk = ~clk;

  pt_walker u_dut (.*);

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (pend) begin
      if (pend_cnt == 0) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem.exists(pend_addr) ? mem[pend_addr] : 64'd0;
        pend <= 1'b0;
      end else pend_cnt <= pend_cnt - 1;
    end
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_write) begin
        mem[mem_req_addr] = mem_req_wdata;
        wr_cnt     = wr_cnt + 1;
        last_waddr = mem_req_addr;
        last_wdata = mem_req_wdata;
      end else begin
        pend      <= 1'b1;
        pend_cnt  <= rsp_lat - 1;
        pend_addr <= mem_req_addr;
        rd_cnt    = rd_cnt + 1;
      end
    end
    mem_req_ready <= stall ? ~mem_req_ready : 1'b1;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] va_of(input int i3, input int i2, input int i1, input int i0,
                                        input int off);
    logic [47:0] low;
    low = {i3[8:0], i2[8:0], i1[8:0], i0[8:0], off[11:0]};
    return {{16{low[47]}}, low};
  endfunction

  task automatic walk(input logic [63:0] va, input logic [1:0] acc);
    @(negedge clk);
    rd0 = rd_cnt; wr0 = wr_cnt;
    req_valid = 1'b1; req_vaddr = va; req_access = acc;
    @(negedge clk);
    req_valid = 1'b0;
    for (int n = 0; n < 500 && !done; n++) @(negedge clk);
    r_fault = fault_code; r_size = page_size; r_pa = pa; r_perm = perm;
    chk("R10 done seen", {63'd0, done}, 64'd1);
  endtask

  task automatic t_reset;
    chk("R10 reset busy", {63'd0, busy}, 0);
    chk("R10 reset done", {63'd0, done}, 0);
    chk("R10 reset memreq", {63'd0, mem_req_valid}, 0);
  endtask

  task automatic t_basic;
    walk(va_of(1, 2, 3, 4, 'h123), 2'd0);
    chk("R9 4K pa", r_pa, 52'h12345123);
    chk("R9 fault none", r_fault, 0);
    chk("R6 size 4K", r_size, 0);
    chk("R5 perm read-only leaf", r_perm, 3'b110);
    chk("R1 four reads", rd_cnt - rd0, 4);
    chk("R7 no write when accessed", wr_cnt - wr0, 0);
    walk(va_of(1, 2, 3, 4, 'h123), 2'd2);
    chk("R8 fetch sets no dirty", wr_cnt - wr0, 0);
  endtask

  task automatic t_accessed;
    mem[52'h2010] = 64'h3007;
    walk(va_of(1, 2, 3, 4, 'h0), 2'd0);
    chk("R7 one write-back", wr_cnt - wr0, 1);
    chk("R7 wb addr", last_waddr, 52'h2010);
    chk("R7 wb data", last_wdata, 64'h3027);
    walk(va_of(1, 2, 3, 4, 'h0), 2'd0);
    chk("R7 no second write", wr_cnt - wr0, 0);
  endtask

  task automatic t_dirty;
    mem[52'h4020] = 64'h12345027;
    walk(va_of(1, 2, 3, 4, 'h7ff), 2'd1);
    chk("R8 dirty write count", wr_cnt - wr0, 1);
    chk("R8 dirty wb addr", last_waddr, 52'h4020);
    chk("R8 dirty wb data", last_wdata, 64'h12345067);
    chk("R5 perm writable", r_perm, 3'b111);
    chk("R9 pa", r_pa, 52'h123457ff);
  endtask

  task automatic t_large;
    mem[52'h3028] = 64'h400000A7;
    walk(va_of(1, 2, 5, 'h1AB, 'h456), 2'd0);
    chk("R6 2M size", r_size, 1);
    chk("R9 2M pa", r_pa, 52'h401AB456);
    chk("R6 2M reads", rd_cnt - rd0, 3);
    mem[52'h3030] = 64'h400020A7;
    walk(va_of(1, 2, 6, 0, 0), 2'd0);
    chk("R6 2M misaligned", r_fault, 3);
    mem[52'h3038] = 64'h400010A7;
    walk(va_of(1, 2, 7, 1, 2), 2'd0);
    chk("R6 bit12 allowed", r_fault, 0);
    chk("R6 bit12 pa", r_pa, 52'h40001002);
    mem[52'h2018] = 64'h800000A7;
    walk(va_of(1, 3, 1, 2, 3), 2'd0);
    chk("R6 1G size", r_size, 2);
    chk("R9 1G pa", r_pa, 52'h80202003);
  endtask

  task automatic t_faults;
    walk(va_of(1, 2, 8, 0, 0), 2'd0);
    chk("R3 not present", r_fault, 2);
    chk("R3 reads stop", rd_cnt - rd0, 3);
    mem[52'h1010] = 64'h20A7;
    walk(va_of(2, 0, 0, 0, 0), 2'd0);
    chk("R4 top PS", r_fault, 3);
    chk("R4 top PS reads", rd_cnt - rd0, 1);
    mem[52'h2020] = (64'd1 << 45) | 64'h3027;
    walk(va_of(1, 4, 3, 4, 0), 2'd0);
    chk("R4 high pa bit", r_fault, 3);
    mem[52'h2028] = (64'd1 << 63) | 64'h3027;
    nx_enable = 1'b0;
    walk(va_of(1, 5, 3, 4, 0), 2'd0);
    chk("R4 nx reserved", r_fault, 3);
    nx_enable = 1'b1;
    walk(va_of(1, 5, 3, 4, 'h123), 2'd0);
    chk("R5 nx allowed fault", r_fault, 0);
    chk("R5 exec cleared", r_perm, 3'b010);
  endtask

  task automatic t_canonical;
    walk(64'h0000_8000_0000_0000, 2'd0);
    chk("R2 gp fault", r_fault, 1);
    chk("R2 no reads", rd_cnt - rd0, 0);
    walk(64'hFFFF_0000_0000_0000, 2'd0);
    chk("R2 gp upper ones", r_fault, 1);
    mem[52'h1800] = 64'h2027;
    walk(va_of(256, 2, 3, 4, 'h123), 2'd0);
    chk("R2 canonical high ok", r_fault, 0);
    chk("R1 high index pa", r_pa, 52'h12345123);
  endtask

  task automatic t_stall;
    stall = 1'b1; rsp_lat = 3;
    @(negedge clk);
    rd0 = rd_cnt;
    req_valid = 1'b1; req_vaddr = va_of(1, 2, 3, 4, 'h55); req_access = 2'd0;
    @(negedge clk); req_valid = 1'b0;
    repeat (3) @(negedge clk);
    req_valid = 1'b1; req_vaddr = 64'h0000_8000_0000_0000;
    @(negedge clk); req_valid = 1'b0;
    for (int n = 0; n < 500 && !done; n++) @(negedge clk);
    chk("R10 stalled walk pa", pa, 52'h12345055);
    chk("R10 busy strobe ignored", fault_code, 0);
    chk("R10 reads once", rd_cnt - rd0, 4);
    @(negedge clk);
    chk("R10 done one cycle", {63'd0, done}, 0);
    for (int n = 0; n < 5; n++) begin
      @(negedge clk);
      if (done) chk("R10 extra done", 1, 0);
    end
    chk("R10 no extra reads", rd_cnt - rd0, 4);
    stall = 1'b0; rsp_lat = 1;
  endtask

  initial begin
    mem[52'h1008] = 64'h2027;
    mem[52'h2010] = 64'h3027;
    mem[52'h3018] = 64'h4027;
    mem[52'h4020] = 64'h12345065;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_basic;
    t_accessed;
    t_dirty;
    mem[52'h4020] = 64'h12345065;
    t_large;
    t_faults;
    t_canonical;
    t_stall;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule